// File: doc/BRIEF.md
# Thermal Throttle Controller

This block guards a processor core against overheating. It compares a digital die temperature code with a limit that software can program and, when the core runs hot with thermal monitoring enabled, it starts throttling. During such throttling it pulls the shared open-drain hot pin low, requests the minimum frequency and its matching voltage code, and turns on clock modulation. Other agents on the board may also pull the hot pin low. The block senses the pin through a synchronizer and treats a qualified external assertion as a request to go to the minimum operating point only. In that case it leaves clock modulation off and holds the low point for as long as the pin stays asserted.

Apart from the throttle path, a catastrophic trip latch compares the temperature with a hard-wired constant. The latch sets whatever the monitor enable says. Once set it stays set until the block is reset. The limit is a build-time constant and no port can read or change it.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: After reset `freq_ratio_o`=32 and `vid_o`=0x48 (the nominal point), and `hot_drive_o`, `clk_mod_en_o` and `trip_o` are 0.
- R2: With `tm_en_i`=1 and `temp_i` >= `throttle_limit_i`, the block drives `hot_drive_o`=1 one clock later and selects the minimum point (`freq_ratio_o`=8, `vid_o`=0x20) one clock after that.
- R3: During internally caused throttling `clk_mod_en_o` is 1.
- R4: Internal throttling, once active, holds while `temp_i` + HYST >= `throttle_limit_i` (HYST=2) and ends once `temp_i` + HYST < `throttle_limit_i`.
- R5: With `tm_en_i`=0 no internal throttling occurs at any temperature, and clearing `tm_en_i` ends active internal throttling.
- R6: A qualified external low level on the hot pin (`hot_sense_n_i`=0 while the block is not driving) selects the minimum point (ratio 8, voltage code 0x20).
- R7: During externally caused throttling `clk_mod_en_o` stays 0 and `hot_drive_o` stays 0.
- R8: Externally caused throttling lasts as long as the pin is held low and ends only after the pin is released.
- R9: The pin sense passes through a two-flop synchronizer and needs two consecutive asserted samples. A low pulse of one clock is ignored.
- R10: The operating point returns to nominal one clock after every throttle cause has cleared.
- R11: `trip_o` sets one clock after `temp_i` >= 120, whatever the value of `tm_en_i`.
- R12: `trip_o` stays 1 whatever the temperature and enable do, and only reset clears it.
- R13: The block's own drive of the pin is not mistaken for an external assertion. After internal throttling ends, the block returns to nominal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous cold reset |
| temp_i | input | TEMP_W | Digital temperature code |
| tm_en_i | input | 1 | Thermal monitor enable |
| throttle_limit_i | input | TEMP_W | Programmable internal throttle limit |
| hot_sense_n_i | input | 1 | Sensed hot pin level, active low |
| hot_drive_o | output | 1 | Open-drain pull-down request for the hot pin |
| freq_ratio_o | output | 6 | Requested frequency ratio |
| vid_o | output | 8 | Requested voltage code |
| clk_mod_en_o | output | 1 | Clock modulation enable |
| trip_o | output | 1 | Latched catastrophic trip |

## Verification
The throttle path gets a temperature sweep that rises to the limit and then steps down through the hysteresis band one degree at a time. This tells a correct release point apart from a release that comes one degree early or one degree late. A long external hold, a one-clock external glitch and a release of the block's own drive separate three cases: real external assertions, unqualified noise, and the block's own echo on the pin. Clock modulation is compared between the internal and external causes. The trip latch is driven with the monitor disabled and then cooled, to show that it ignores the enable and stays set.

// File: rtl/thermal_pkg.sv
package thermal_pkg;
    localparam int FREQ_W = 6;
    localparam int VID_W  = 8;

    typedef struct packed {
        logic [FREQ_W-1:0] ratio;
        logic [VID_W-1:0]  vid;
    } op_point_t;

    localparam op_point_t OP_NOM = '{ratio: 6'd32, vid: 8'h48};
    localparam op_point_t OP_MIN = '{ratio: 6'd8,  vid: 8'h20};
endpackage

// File: rtl/hotpin_qual.sv
module hotpin_qual #(
    parameter int SYNC_STAGES  = 2,
    parameter int QUAL_SAMPLES = 2,
    parameter int MASK_CYC     = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_n_i,
    input  logic own_drive_i,
    output logic ext_hot_o
);
    localparam int CNT_W = $clog2(QUAL_SAMPLES + 1);
    localparam int MSK_W = $clog2(MASK_CYC + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CNT_W-1:0]       cnt;
        logic [MSK_W-1:0]       mask;
    } st_t;

    st_t st_d, st_q;
    logic sensed;

    assign sensed = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], ~pin_n_i};
        if (own_drive_i)
            st_d.mask = MSK_W'(MASK_CYC);
        else if (st_q.mask != '0)
            st_d.mask = st_q.mask - 1'b1;
        if (sensed && !own_drive_i && st_q.mask == '0) begin
            if (st_q.cnt != CNT_W'(QUAL_SAMPLES))
                st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ext_hot_o = (st_q.cnt == CNT_W'(QUAL_SAMPLES));

    // R9
    qual_prev_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ext_hot_o) |-> $past(sensed));
    // R13
    own_drive_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        own_drive_i |=> !ext_hot_o);
endmodule

// File: rtl/tm_hyst.sv
module tm_hyst #(
    parameter int TEMP_W = 8,
    parameter int HYST   = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic [TEMP_W-1:0] limit_i,
    input  logic              en_i,
    output logic              hot_o
);
    localparam int XW = TEMP_W + 1;

    typedef struct packed {
        logic hot;
    } st_t;

    st_t st_d, st_q;
    logic [XW-1:0] temp_plus;
    logic          above, cooled;

    assign temp_plus = {1'b0, temp_i} + XW'(HYST);
    assign above     = (temp_i >= limit_i);
    assign cooled    = (temp_plus < {1'b0, limit_i});

    always_comb begin
        st_d = st_q;
        if (!en_i)       st_d.hot = 1'b0;
        else if (above)  st_d.hot = 1'b1;
        else if (cooled) st_d.hot = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign hot_o = st_q.hot;

    // R4
    hyst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hot_o && en_i && !cooled) |=> hot_o);
    // R5
    tm_disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !hot_o);
endmodule

// File: rtl/trip_latch.sv
module trip_latch #(
    parameter int TEMP_W    = 8,
    parameter int TRIP_TEMP = 120
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [TEMP_W-1:0] temp_i,
    output logic              trip_o
);
    typedef struct packed {
        logic trip;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (temp_i >= TEMP_W'(TRIP_TEMP)) st_d.trip = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign trip_o = st_q.trip;

    // R11
    trip_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (temp_i >= TEMP_W'(TRIP_TEMP)) |=> trip_o);
    // R12
    trip_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trip_o |=> trip_o);
endmodule

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl #(
    parameter int TEMP_W       = 8,
    parameter int HYST         = 2,
    parameter int TRIP_TEMP    = 120,
    parameter int SYNC_STAGES  = 2,
    parameter int QUAL_SAMPLES = 2,
    parameter int MASK_CYC     = 4
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [TEMP_W-1:0]             temp_i,
    input  logic                          tm_en_i,
    input  logic [TEMP_W-1:0]             throttle_limit_i,
    input  logic                          hot_sense_n_i,
    output logic                          hot_drive_o,
    output logic [thermal_pkg::FREQ_W-1:0] freq_ratio_o,
    output logic [thermal_pkg::VID_W-1:0]  vid_o,
    output logic                          clk_mod_en_o,
    output logic                          trip_o
);
    import thermal_pkg::*;

    typedef struct packed {
        op_point_t op;
        logic      clk_mod;
    } st_t;

    st_t  st_d, st_q;
    logic int_hot, ext_hot;

    tm_hyst #(.TEMP_W(TEMP_W), .HYST(HYST)) u_hyst (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .temp_i  (temp_i),
        .limit_i (throttle_limit_i),
        .en_i    (tm_en_i),
        .hot_o   (int_hot)
    );

    hotpin_qual #(.SYNC_STAGES(SYNC_STAGES), .QUAL_SAMPLES(QUAL_SAMPLES),
                  .MASK_CYC(MASK_CYC)) u_qual (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .pin_n_i     (hot_sense_n_i),
        .own_drive_i (int_hot),
        .ext_hot_o   (ext_hot)
    );

    trip_latch #(.TEMP_W(TEMP_W), .TRIP_TEMP(TRIP_TEMP)) u_trip (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .temp_i (temp_i),
        .trip_o (trip_o)
    );

    always_comb begin
        st_d         = st_q;
        st_d.op      = (int_hot || ext_hot) ? OP_MIN : OP_NOM;
        st_d.clk_mod = int_hot && !ext_hot;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.op      <= OP_NOM;
            st_q.clk_mod <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hot_drive_o  = int_hot;
    assign freq_ratio_o = st_q.op.ratio;
    assign vid_o        = st_q.op.vid;
    assign clk_mod_en_o = st_q.clk_mod;

    // R6
    ext_min_point_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ext_hot |=> (freq_ratio_o == OP_MIN.ratio && vid_o == OP_MIN.vid));
    // R7
    ext_no_mod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ext_hot |=> !clk_mod_en_o);
    // R10
    nominal_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!int_hot && !ext_hot) |=> (freq_ratio_o == OP_NOM.ratio && !clk_mod_en_o));
endmodule

// File: tb/tb_thermal_throttle_ctrl.sv
`timescale 1ns/1ps
module tb_thermal_throttle_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] temp = 8'd40;
    logic       tm_en = 1'b0;
    logic [7:0] limit = 8'd90;
    logic       ext_pull = 1'b0;
    logic       hot_sense_n, hot_drive;
    logic [5:0] ratio;
    logic [7:0] vid;
    logic       clk_mod, trip;
    int         n_chk = 0, n_err = 0;
    bit         finished = 1'b0;

    localparam int NOM_R = 32, MIN_R = 8, NOM_V = 'h48, MIN_V = 'h20;

    always #2.5 clk = ~clk;

    assign hot_sense_n = ~(hot_drive | ext_pull);

    thermal_throttle_ctrl dut (
        .clk_i(clk), .rst_ni(rst_n), .temp_i(temp), .tm_en_i(tm_en),
        .throttle_limit_i(limit), .hot_sense_n_i(hot_sense_n),
        .hot_drive_o(hot_drive), .freq_ratio_o(ratio), .vid_o(vid),
        .clk_mod_en_o(clk_mod), .trip_o(trip)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        step(1);
        check("R1 ratio", ratio, NOM_R);
        check("R1 vid", vid, NOM_V);
        check("R1 drive", hot_drive, 0);
        check("R1 clk_mod", clk_mod, 0);
        check("R1 trip", trip, 0);
        rst_n = 1'b1;
        step(2);
    endtask

    task automatic t_internal_hyst;
        tm_en = 1'b1; limit = 8'd90; temp = 8'd89;
        step(3);
        check("R2 below limit drive", hot_drive, 0);
        temp = 8'd90;
        step(1);
        check("R2 drive", hot_drive, 1);
        step(1);
        check("R2 ratio", ratio, MIN_R);
        check("R2 vid", vid, MIN_V);
        check("R3 clk_mod", clk_mod, 1);
        temp = 8'd88;
        step(4);
        check("R4 hold at 88", hot_drive, 1);
        check("R4 ratio at 88", ratio, MIN_R);
        temp = 8'd87;
        step(1);
        check("R4 release at 87", hot_drive, 0);
        step(1);
        check("R13 nominal after own drive", ratio, NOM_R);
        step(8);
        check("R13 no false external", ratio, NOM_R);
    endtask

    task automatic t_one_clock_return;
        temp = 8'd95;
        step(3);
        check("R10 throttled", ratio, MIN_R);
        temp = 8'd50;
        step(1);
        check("R10 still min one edge", ratio, MIN_R);
        step(1);
        check("R10 nominal next edge", ratio, NOM_R);
        check("R10 clk_mod off", clk_mod, 0);
    endtask

    task automatic t_disable;
        temp = 8'd100;
        step(3);
        check("R5 enabled throttles", hot_drive, 1);
        tm_en = 1'b0;
        step(1);
        check("R5 disable clears drive", hot_drive, 0);
        step(6);
        check("R5 disabled ratio", ratio, NOM_R);
        check("R5 disabled clk_mod", clk_mod, 0);
        temp = 8'd40;
        step(2);
    endtask

    task automatic t_external;
        ext_pull = 1'b1;
        step(6);
        check("R6 ratio", ratio, MIN_R);
        check("R6 vid", vid, MIN_V);
        check("R7 clk_mod", clk_mod, 0);
        check("R7 drive", hot_drive, 0);
        step(40);
        check("R8 still held", ratio, MIN_R);
        ext_pull = 1'b0;
        step(2);
        check("R8 not early", ratio, MIN_R);
        step(4);
        check("R8 released", ratio, NOM_R);
    endtask

    task automatic t_glitch;
        ext_pull = 1'b1;
        step(1);
        ext_pull = 1'b0;
        for (int i = 0; i < 8; i++) begin
            step(1);
            check("R9 glitch ignored", ratio, NOM_R);
        end
    endtask

    task automatic t_trip;
        tm_en = 1'b0; temp = 8'd119;
        step(2);
        check("R11 below trip", trip, 0);
        temp = 8'd120;
        step(1);
        check("R11 trip with monitor off", trip, 1);
        temp = 8'd30;
        step(5);
        check("R12 sticky cool", trip, 1);
        tm_en = 1'b1;
        step(3);
        check("R12 sticky enable", trip, 1);
        rst_n = 1'b0;
        step(1);
        check("R12 reset clears", trip, 0);
        rst_n = 1'b1;
        step(2);
    endtask

    initial begin
        t_reset();
        t_internal_hyst();
        t_one_clock_return();
        t_disable();
        t_external();
        t_glitch();
        t_trip();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule